// File: doc/BRIEF.md
# External Interrupt Sense Unit (four pins)

This block conditions four asynchronous interrupt pins for an interrupt controller. Each pin is brought into the clock domain through a two-flop synchroniser. Each pin then passes through its own detector, which is set by a 2-bit sense code to respond to a level or to an edge. Pin 0 drives the request of the critical tier. Pins 1 to 3 drive the main-tier requests at indices 1 to 3. The tier encoder that sits downstream is a separate block.

A single control word holds the sense codes, the mask bits and the acknowledge bits of all four pins. Software writes it with `cfg_wr`. In an edge mode, a detected edge is stored in a per-pin latch state machine with two states, `ST_ARMED` and `ST_CAPTURED`. The state machine has three transitions:

- **capture** (`ST_ARMED` to `ST_CAPTURED`) is taken on an edge of the selected polarity.
- **release** (`ST_CAPTURED` to `ST_ARMED`) is taken on an acknowledge when no new edge arrives in that same cycle.
- **discard** (`ST_CAPTURED` to `ST_ARMED`) is taken whenever the pin's sense code selects a level mode.

In every other case the state holds. A masked pin keeps capturing edges but its request stays low.

Top module: `extsense_unit`

## Requirements
- R1: After reset all requests are low, every pin is masked and every sense code is 0, even when the pins are driven high.
- R2: Control word layout: the sense code of pin i is in bits [2i+1:2i], the mask of pin i is bit 8+i (1 hides the request), and the acknowledge of pin i is bit 12+i (write 1). The word is taken on a clock edge where `cfg_wr` is 1. Acknowledge bits are not stored.
- R3: Sense code 0 is active-high level and code 3 is active-low level. In a level mode an unmasked request follows the synchronised pin.
- R4: Sense code 1 captures rising edges only and code 2 captures falling edges only. Edges of the other polarity, and pin changes made while a level code is selected, capture nothing.
- R5: A captured edge keeps the request high until a write with that pin's acknowledge bit set, which clears it one cycle later. Other pins are unaffected.
- R6: If an acknowledge and a new qualifying edge occur in the same cycle, the capture stays set.
- R7: In a level mode, acknowledge writes have no effect. Selecting a level mode discards any captured edge, so a later return to an edge mode shows no request.
- R8: A masked pin still captures edges but its request stays low. On unmask, a capture stored while masked becomes visible.
- R9: Pin 0 drives `crit_req`. Pins 1, 2 and 3 drive `main_req[1]`, `main_req[2]` and `main_req[3]`.
- R10: A pin change reaches a level-mode request after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word: sense codes, masks, acknowledge bits |
| crit_req | output | 1 | Critical-tier request from pin 0 |
| main_req | output | 3 | Main-tier requests, indices 3 down to 1, from pins 3..1 |

## Verification
The pins are driven with rising steps and falling steps under every sense code. This shows that each edge mode reacts only to its own polarity and that each level mode reacts to the correct pin value. Patterns that hold the pins steady after an edge, followed by single-pin acknowledges, separate a sticky capture from a request that only follows the pin. Mask-then-unmask sequences and a switch from an edge mode to a level mode and back separate "hidden but stored" from "discarded". A final mixed configuration with one pin per code shows that the pin-to-tier mapping and the per-pin field decode are not swapped. Directed cases cover an acknowledge that coincides with an edge and the exact two-edge synchroniser latency.

// File: rtl/extsense_pkg.sv
package extsense_pkg;
    localparam int NPINS    = 4;
    localparam int SENSE_W  = 2;
    localparam int SENSE_BITS = NPINS * SENSE_W;
    localparam int MASK_LSB = SENSE_BITS;
    localparam int ACK_LSB  = MASK_LSB + NPINS;
    localparam int CFG_W    = ACK_LSB + NPINS;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_HIGH = 2'd0,
        SENSE_RISE = 2'd1,
        SENSE_FALL = 2'd2,
        SENSE_LOW  = 2'd3
    } sense_t;

    typedef enum logic {
        ST_ARMED    = 1'b0,
        ST_CAPTURED = 1'b1
    } latch_st_t;
endpackage

// File: rtl/extsense_sync.sv
module extsense_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/extsense_pin.sv
module extsense_pin
    import extsense_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_t sense,
    input  logic   masked,
    input  logic   ack,
    output logic   req
);
    logic      prev_q;
    latch_st_t st_q, st_d;
    logic      is_edge, edge_hit, level_on;

    // previous synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    always_comb begin
        is_edge  = (sense == SENSE_RISE) || (sense == SENSE_FALL);
        edge_hit = ((sense == SENSE_RISE) &&  pin_s && !prev_q) ||
                   ((sense == SENSE_FALL) && !pin_s &&  prev_q);
        level_on = ((sense == SENSE_HIGH) &&  pin_s) ||
                   ((sense == SENSE_LOW)  && !pin_s);
    end

    // next-state: capture / release / discard
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARMED: begin
                if (edge_hit) st_d = ST_CAPTURED;
            end
            ST_CAPTURED: begin
                if (!is_edge)              st_d = ST_ARMED;
                else if (ack && !edge_hit) st_d = ST_ARMED;
            end
            default: st_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ARMED;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        if (masked)       req = 1'b0;
        else if (is_edge) req = (st_q == ST_CAPTURED);
        else              req = level_on;
    end
endmodule

// File: rtl/extsense_unit.sv
module extsense_unit
    import extsense_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] ext_pin,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             crit_req,
    output logic [3:1]       main_req
);
    logic [SENSE_BITS-1:0] sense_q;
    logic [NPINS-1:0]      mask_q;
    logic [NPINS-1:0]      ack_pulse;
    logic [NPINS-1:0]      pin_s;
    logic [NPINS-1:0]      req_vec;

    // shared control register (acknowledge bits are pulses, not stored)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '1;
        end else if (cfg_wr) begin
            sense_q <= cfg_wdata[SENSE_BITS-1:0];
            mask_q  <= cfg_wdata[MASK_LSB +: NPINS];
        end
    end

    assign ack_pulse = cfg_wr ? cfg_wdata[ACK_LSB +: NPINS] : '0;

    extsense_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_pin),
        .q     (pin_s)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        extsense_pin i_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_s  (pin_s[g]),
            .sense  (sense_t'(sense_q[g*SENSE_W +: SENSE_W])),
            .masked (mask_q[g]),
            .ack    (ack_pulse[g]),
            .req    (req_vec[g])
        );
    end

    assign crit_req = req_vec[0];
    assign main_req = req_vec[3:1];
endmodule

// File: rtl/extsense_chk.sv
module extsense_chk
    import extsense_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr,
    input logic [SENSE_BITS-1:0] sense_q,
    input logic [NPINS-1:0]      mask_q,
    input logic [NPINS-1:0]      ext_pin,
    input logic [NPINS-1:0]      pin_s,
    input logic [NPINS-1:0]      req
);
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end
    wire warm = (age_q == 2'd3);

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        wire [1:0] code   = sense_q[g*SENSE_W +: SENSE_W];
        wire       edge_m = (code == 2'd1) || (code == 2'd2);

        // R8
        masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[g] |-> !req[g]);

        // R5
        held_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_m && req[g] && !cfg_wr) |=> req[g]);

        // R3
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && !edge_m && !mask_q[g]) |->
            (req[g] == ($past(ext_pin[g], 2) ^ (code == 2'd3))));

        // R4
        edge_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && edge_m && $rose(req[g]) && !$past(cfg_wr)) |->
            ($past(pin_s[g]) != $past(pin_s[g], 2)));
    end
endmodule

bind extsense_unit extsense_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .sense_q (sense_q),
    .mask_q  (mask_q),
    .ext_pin (ext_pin),
    .pin_s   (pin_s),
    .req     ({main_req, crit_req})
);

// File: tb/test_extsense_unit.sv
module test_extsense_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_pin = 4'b0000;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = 16'h0000;
    logic        crit_req;
    logic [3:1]  main_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extsense_unit i_extsense_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .crit_req  (crit_req),
        .main_req  (main_req)
    );

    // {wr, wdata[15:0], pins[3:0], expected {main3,main2,main1,crit}}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 16'h0000, 4'b0000, 4'b0000},  // 0  R2 unmask, all level-high
        {1'b0, 16'h0000, 4'b1010, 4'b1010},  // 1  R3 level-high follows
        {1'b1, 16'h0003, 4'b1010, 4'b1011},  // 2  R3 pin0 active-low
        {1'b1, 16'hF003, 4'b1010, 4'b1011},  // 3  R7 ack ignored in level
        {1'b1, 16'h0055, 4'b0000, 4'b0000},  // 4  R4 falling ignored in rise
        {1'b0, 16'h0000, 4'b0110, 4'b0110},  // 5  R4 rising captured
        {1'b0, 16'h0000, 4'b0000, 4'b0110},  // 6  R5 sticky
        {1'b1, 16'h2055, 4'b0000, 4'b0100},  // 7  R5 ack pin1 only
        {1'b1, 16'h0455, 4'b0000, 4'b0000},  // 8  R8 mask hides pin2
        {1'b0, 16'h0000, 4'b1001, 4'b1001},  // 9  R8 others capture
        {1'b1, 16'h0055, 4'b1001, 4'b1101},  // 10 R8 unmask reveals
        {1'b1, 16'hF0AA, 4'b1001, 4'b0000},  // 11 R5 ack all
        {1'b0, 16'h0000, 4'b0000, 4'b1001},  // 12 R4 falling captured
        {1'b1, 16'h00FF, 4'b0000, 4'b1111},  // 13 R3 active-low level
        {1'b1, 16'h0055, 4'b0000, 4'b0000},  // 14 R7 level discarded captures
        {1'b1, 16'h00C9, 4'b0010, 4'b1000},  // 15 R4 mixed codes
        {1'b0, 16'h0000, 4'b0001, 4'b1011}   // 16 R9 tier mapping
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2";
            1, 2, 13: return "R3";
            3, 14: return "R7";
            4, 5, 12, 15: return "R4";
            6, 7, 11: return "R5";
            8, 9, 10: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check4(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {main_req, crit_req};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: req actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [15:0] wd, input logic [3:0] pins);
        @(negedge clk);
        cfg_wr = wr;
        cfg_wdata = wd;
        ext_pin = pins;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state with pins high
        ext_pin = 4'b1111;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check4("R1", 4'b0000);
        ext_pin = 4'b0000;
        repeat (4) @(posedge clk);
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][24], VEC[i][23:8], VEC[i][7:4]);
            check4(vec_tag(i), VEC[i][3:0]);
        end

        // R10: two-edge latency, level-high unmasked
        step(1'b1, 16'h0000, 4'b0000);
        check4("R10", 4'b0000);
        @(negedge clk);
        ext_pin = 4'b0001;
        @(posedge clk);
        @(negedge clk);
        check4("R10", 4'b0000);
        @(posedge clk);
        @(negedge clk);
        check4("R10", 4'b0001);

        // R6: acknowledge coinciding with a new rising edge
        step(1'b1, 16'h0055, 4'b0000);
        check4("R6", 4'b0000);
        @(negedge clk);
        ext_pin = 4'b0001;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = 16'h1055;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = 16'h0000;
        check4("R6", 4'b0001);
        step(1'b1, 16'h1055, 4'b0001);
        check4("R5", 4'b0000);

        // R9: single main pin reaches only its own index
        step(1'b0, 16'h0000, 4'b0101);
        check4("R9", 4'b0100);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule